// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block sits between the digital sample path and the current-source array of a high-speed current-steering DAC. It captures a 14-bit code on a clock edge and turns it into switch controls for three tiers of sources. The top tier is a set of identical large sources driven by a thermometer code. The middle tier is a set of smaller sources, built from unit cells and also driven by a thermometer code. The bottom tier is a few binary-weighted sources driven straight from the low bits.

Each source has a pair of complementary controls. One control steers its current to output A and the other steers it to output B. All controls leave a second register stage on the same edge, so every segment switches at once and the latency is fixed.

For checking, the block also rebuilds two digital currents, in LSB units, from the switch lines it actually drives. These are the current at output A and the current at output B.

Top module: `dac_seg_decoder`

## Requirements
- R1: A code on `din` appears on every switch output and on both model currents exactly two rising clock edges after it is sampled.
- R2: Within `msb_a` (31 lines), line i is high exactly when the code's upper field, bits 13:9, is greater than i. The high lines therefore fill upward from line 0.
- R3: Within `mid_a` (15 lines), line i is high exactly when the middle field, bits 8:5, is greater than i.
- R4: `lsb_a` equals the low field, bits 4:0, bit for bit.
- R5: Every B control is the inverse of its A control, so each source goes to exactly one output.
- R6: The weights are 512 LSB for a top-tier source, 32 LSB for a middle-tier source and 2^j LSB for `lsb_a[j]`. With these weights, `cur_a` equals the code that was applied.
- R7: Code 0 gives `cur_a` = 0. Code 16383 gives `cur_a` = 16383 and `cur_b` = 0.
- R8: `cur_a` + `cur_b` equals 16383 in every cycle.
- R9: While `rst_n` is low and after its release, until new data arrives, all A controls are 0, all B controls are 1, `cur_a` is 0 and `cur_b` is 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 14 | DAC input code, offset binary |
| msb_a | output | 31 | Top-tier thermometer, steer to A |
| msb_b | output | 31 | Top-tier thermometer, steer to B |
| mid_a | output | 15 | Middle-tier thermometer, steer to A |
| mid_b | output | 15 | Middle-tier thermometer, steer to B |
| lsb_a | output | 5 | Binary sources, steer to A |
| lsb_b | output | 5 | Binary sources, steer to B |
| cur_a | output | 14 | Model current at output A, in LSB |
| cur_b | output | 14 | Model current at output B, in LSB |

## Verification
The codes tried are:
- zero and full scale, which pin the two ends of the transfer;
- codes one below and at a top-tier boundary (511/512, 8191/8192), where the thermometer tiers roll over and a wrong weight or an off-by-one compare shows up;
- one-hot field patterns, which isolate each tier so that a swapped or mis-ordered field is exposed;
- a back-to-back stream of changing codes, which separates a correct two-edge latency from a one- or three-edge one.

Every pattern also confirms that each pair is complementary and that the two model currents add up to full scale.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  localparam int unsigned FULL_W = 14;

  // number of set bits in a vector of up to 32 lines
  function automatic int unsigned line_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // current contributed by the three tiers, in LSB units
  function automatic int unsigned tier_sum(input int unsigned top_n,
                                           input int unsigned mid_n,
                                           input int unsigned low_v,
                                           input int unsigned low_w,
                                           input int unsigned mid_w);
    return (top_n << (mid_w + low_w)) + (mid_n << low_w) + low_v;
  endfunction
endpackage

// File: rtl/dac_therm_dec.sv
module dac_therm_dec #(
  parameter int unsigned IN_W  = 5,
  parameter int unsigned OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  field,
  output logic [OUT_W-1:0] lines
);
  for (genvar g = 0; g < OUT_W; g++) begin : g_line
    assign lines[g] = (field > IN_W'(g));
  end
endmodule

// File: rtl/dac_switch_reg.sv
module dac_switch_reg #(
  parameter int unsigned W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= '0;
      q_b <= '1;
    end else begin
      q_a <= d_a;
      q_b <= ~d_a;
    end
  end

  // each source lands on exactly one output
  assert_pair_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_a ^ q_b) == {W{1'b1}});
endmodule

// File: rtl/dac_current_model.sv
module dac_current_model
  import dac_seg_pkg::*;
#(
  parameter int unsigned MSB_W = 5,
  parameter int unsigned MID_W = 4,
  parameter int unsigned LSB_W = 5,
  localparam int unsigned TOP_N = (1 << MSB_W) - 1,
  localparam int unsigned MID_N = (1 << MID_W) - 1,
  localparam int unsigned OUT_W = MSB_W + MID_W + LSB_W
) (
  input  logic [TOP_N-1:0] top_lines,
  input  logic [MID_N-1:0] mid_lines,
  input  logic [LSB_W-1:0] low_lines,
  output logic [OUT_W-1:0] current
);
  int unsigned total;

  always_comb begin
    total = tier_sum(line_count(32'(top_lines)), line_count(32'(mid_lines)),
                     int'(low_lines), LSB_W, MID_W);
    current = total[OUT_W-1:0];
  end
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
  import dac_seg_pkg::*;
#(
  parameter int unsigned DATA_W = FULL_W,
  parameter int unsigned MSB_W  = 5,
  parameter int unsigned MID_W  = 4,
  localparam int unsigned LSB_W = DATA_W - MSB_W - MID_W,
  localparam int unsigned TOP_N = (1 << MSB_W) - 1,
  localparam int unsigned MID_N = (1 << MID_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [TOP_N-1:0]  msb_a,
  output logic [TOP_N-1:0]  msb_b,
  output logic [MID_N-1:0]  mid_a,
  output logic [MID_N-1:0]  mid_b,
  output logic [LSB_W-1:0]  lsb_a,
  output logic [LSB_W-1:0]  lsb_b,
  output logic [DATA_W-1:0] cur_a,
  output logic [DATA_W-1:0] cur_b
);
  localparam logic [DATA_W-1:0] FS = '1;

  // input data register
  logic [DATA_W-1:0] code_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= din;
  end

  wire [MSB_W-1:0] top_field = code_q[DATA_W-1 -: MSB_W];
  wire [MID_W-1:0] mid_field = code_q[LSB_W +: MID_W];
  wire [LSB_W-1:0] low_field = code_q[LSB_W-1:0];

  logic [TOP_N-1:0] top_therm;
  logic [MID_N-1:0] mid_therm;

  dac_therm_dec #(.IN_W(MSB_W)) u_top_dec (.field(top_field), .lines(top_therm));
  dac_therm_dec #(.IN_W(MID_W)) u_mid_dec (.field(mid_field), .lines(mid_therm));

  // common switch register stage
  dac_switch_reg #(.W(TOP_N)) u_top_sw (.clk(clk), .rst_n(rst_n), .d_a(top_therm),
                                        .q_a(msb_a), .q_b(msb_b));
  dac_switch_reg #(.W(MID_N)) u_mid_sw (.clk(clk), .rst_n(rst_n), .d_a(mid_therm),
                                        .q_a(mid_a), .q_b(mid_b));
  dac_switch_reg #(.W(LSB_W)) u_low_sw (.clk(clk), .rst_n(rst_n), .d_a(low_field),
                                        .q_a(lsb_a), .q_b(lsb_b));

  // digital current models rebuilt from driven lines
  dac_current_model #(.MSB_W(MSB_W), .MID_W(MID_W), .LSB_W(LSB_W)) u_model_a (
    .top_lines(msb_a), .mid_lines(mid_a), .low_lines(lsb_a), .current(cur_a));
  dac_current_model #(.MSB_W(MSB_W), .MID_W(MID_W), .LSB_W(LSB_W)) u_model_b (
    .top_lines(msb_b), .mid_lines(mid_b), .low_lines(lsb_b), .current(cur_b));

  // cycles since reset, saturating at the pipeline depth
  logic [1:0] settle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           settle <= '0;
    else if (settle != 2) settle <= settle + 2'd1;
  end
  wire pipe_full = (settle == 2'd2);

  assert_two_edge_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_full |-> cur_a == $past(din, 2));
  assert_top_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msb_a & (msb_a + 1'b1)) == '0);
  assert_mid_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_a & (mid_a + 1'b1)) == '0);
  assert_sum_fullscale_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_a + cur_b == FS);
endmodule

// File: tb/tb_dac_seg_decoder.sv
module tb_dac_seg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] din = '0;
  logic [30:0] msb_a, msb_b;
  logic [14:0] mid_a, mid_b;
  logic [4:0]  lsb_a, lsb_b;
  logic [13:0] cur_a, cur_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_seg_decoder dut (.clk(clk), .rst_n(rst_n), .din(din), .msb_a(msb_a), .msb_b(msb_b),
    .mid_a(mid_a), .mid_b(mid_b), .lsb_a(lsb_a), .lsb_b(lsb_b), .cur_a(cur_a), .cur_b(cur_b));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] therm(input int n, input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = (i < n);
    return r;
  endfunction

  // full check of all outputs against code c
  task automatic expect_code(input logic [13:0] c);
    logic [30:0] em;
    logic [14:0] ek;
    em = 31'(therm(int'(c[13:9]), 31));
    ek = 15'(therm(int'(c[8:5]), 15));
    check(msb_a == em, "R2", "msb_a", msb_a, em);
    check(mid_a == ek, "R3", "mid_a", mid_a, ek);
    check(lsb_a == c[4:0], "R4", "lsb_a", lsb_a, c[4:0]);
    check(msb_b == ~msb_a && mid_b == ~mid_a && lsb_b == ~lsb_a, "R5", "pairs",
          {msb_b, mid_b, lsb_b}, {~msb_a, ~mid_a, ~lsb_a});
    check(cur_a == c, "R6", "cur_a", cur_a, c);
    check(int'(cur_a) + int'(cur_b) == 16383, "R8", "sum", int'(cur_a) + int'(cur_b), 16383);
  endtask

  task automatic apply(input logic [13:0] c);
    @(negedge clk) din = c;
    @(negedge clk);
    @(negedge clk);
    expect_code(c);
  endtask

  task automatic t_reset();
    din = 14'h1234;
    @(negedge clk);
    check(msb_a == '0 && mid_a == '0 && lsb_a == '0, "R9", "A low in reset",
          {msb_a, mid_a, lsb_a}, 0);
    check(&msb_b && &mid_b && &lsb_b, "R9", "B high in reset", {msb_b, mid_b, lsb_b}, 51'h7ffffffffffff);
    check(cur_a == 0 && cur_b == 16383, "R9", "currents in reset", cur_b, 16383);
    din = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_a == 0, "R9", "cur_a after release", cur_a, 0);
  endtask

  task automatic t_ends();
    apply(14'd0);
    check(cur_a == 0, "R7", "zero code", cur_a, 0);
    apply(14'd16383);
    check(cur_a == 16383 && cur_b == 0, "R7", "full code", cur_b, 0);
  endtask

  task automatic t_boundaries();
    apply(14'd511);
    apply(14'd512);
    apply(14'd8191);
    apply(14'd8192);
    apply(14'd31);
    apply(14'd32);
  endtask

  task automatic t_one_hot();
    for (int b = 0; b < 14; b++) apply(14'(1 << b));
  endtask

  // back-to-back codes: output at negedge n+2 reflects code driven at negedge n
  task automatic t_stream();
    logic [13:0] seq [8];
    seq = '{14'd100, 14'd16000, 14'd7, 14'd4096, 14'd9999, 14'd1, 14'd12345, 14'd600};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) check(cur_a == seq[i-2], "R1", "stream latency", cur_a, seq[i-2]);
      if (i < 8) din = seq[i];
    end
  endtask

  initial begin
    t_reset();
    t_ends();
    t_boundaries();
    t_one_hot();
    t_stream();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule